// File: doc/BRIEF.md
# Auto-incrementing Buffer Access Port

This block lets a host processor fill or drain two byte-wide transfer buffers, one for isochronous traffic and one for asynchronous traffic, through a single 16-bit data register. The processor first loads a byte count into a transfer-length register. It then writes one command byte that chooses the buffer and the direction. After that it makes as many 16-bit data accesses as the transfer needs. The command is not repeated between them.

Every accepted access moves two bytes. The low half of the word maps to the even byte address and the high half maps to the odd byte address that follows it. The internal byte pointer then advances by two. When the pointer meets the programmed count, the transfer ends. An end-of-transfer pulse is raised, a sticky interrupt flag is set, and a per-buffer completion flag is set. Further data accesses have no effect until the next command. For reads, the block fetches each word ahead of time, so the data register already holds the next word whenever the processor reads it.

Top module: `bufport_top`

## Requirements
- R1: Command codes are decoded as follows. 0x40 reads the isochronous buffer (buffer 0) and 0xC0 writes it. 0x41 reads the asynchronous buffer (buffer 1) and 0xC1 writes it. Bit 7 set means write. Any other code is ignored and leaves a transfer in progress running undisturbed.
- R2: Every valid command restarts the byte pointer at 0, so the first access of a transfer touches bytes 0 and 1.
- R3: An accepted write stores dat_wdata[7:0] at the even byte address given by the pointer and dat_wdata[15:8] at the next odd address. The pointer then advances by 2.
- R4: On a read transfer, dat_rdata carries the even byte in bits 7:0 and the odd byte in bits 15:8. The first word is present in the cycle after the command edge, and each further word is present in the cycle after the edge that accepted the previous read.
- R5: The two buffers are independent. Traffic to one buffer never changes the contents of the other.
- R6: The access during which pointer+2 reaches or passes the count ends the transfer. xfer_eot is high for exactly the cycle after that access's edge.
- R7: When the count is odd, the final write stores only its low byte. The odd byte after it keeps its previous contents.
- R8: Data accesses made after end-of-transfer, and accesses in the direction opposite to the command, are ignored. The buffer contents, the pointer and dat_rdata stay unchanged until the next valid command.
- R9: int_status bit 2 becomes 1 one cycle after xfer_eot and stays 1 until int_clr_we is pulsed with int_clr_data bit 2 set. A set and a clear in the same cycle leave the bit at 1. All other int_status bits read 0, and irq equals bit 2.
- R10: buf_status bit 0 (buffer 0) or bit 1 (buffer 1) is set at the same edge as the interrupt bit, for the buffer that finished. It is cleared by the next valid command that selects that buffer.
- R11: A valid command issued while the count is 0 ends at once. xfer_eot is high in the cycle after the command edge, and no data access is accepted afterwards.
- R12: After reset, dat_rdata, int_status, irq, buf_status and xfer_eot are all 0 and no transfer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_we | input | 1 | Load the transfer-length register |
| cnt_wdata | input | CNT_W | Transfer length in bytes |
| cmd_we | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| dat_wr | input | 1 | Data port write strobe |
| dat_wdata | input | 16 | Data port write word |
| dat_rd | input | 1 | Data port read strobe (consumes dat_rdata) |
| dat_rdata | output | 16 | Prefetched read word |
| int_clr_we | input | 1 | Interrupt status clear strobe |
| int_clr_data | input | 8 | Write-1-to-clear mask |
| int_status | output | 8 | Interrupt status, bit 2 is transfer done |
| irq | output | 1 | Interrupt request |
| buf_status | output | 2 | Per-buffer transfer-complete flags |
| xfer_eot | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A command takes effect at the edge that samples it. The pointer reset, the prefetched first read word and the cleared buffer flag are all visible in the next cycle, and a zero-count end pulse also appears in that cycle. A data access is seen at one edge, and its end pulse is visible right after that edge. The interrupt and buffer flags follow one edge later. The bench drives every strobe for one cycle starting at a falling edge and samples at the following falling edge, which falls between those two register stages. Buffer contents are checked by reading them back through the port and comparing against a byte model that the bench updates from the lane and odd-count rules.

// File: rtl/bufport_pkg.sv
// Shared command encoding and types for the buffer access port.
// Assumes: two buffers, selected by bit 0 of the opcode field.
package bufport_pkg;

    localparam logic [6:0] OP_ISO = 7'h40;
    localparam logic [6:0] OP_ASY = 7'h41;
    localparam int         WR_BIT = 7;

    typedef enum logic {
        BUF_ISO = 1'b0,
        BUF_ASY = 1'b1
    } buf_sel_t;

    typedef struct packed {
        logic     valid;
        logic     wr;
        buf_sel_t sel;
    } cmd_t;

    // Turn a command byte into valid/direction/buffer fields.
    function automatic cmd_t decode_cmd(input logic [7:0] code);
        cmd_t c;
        c.valid = (code[6:0] == OP_ISO) || (code[6:0] == OP_ASY);
        c.wr    = code[WR_BIT];
        c.sel   = (code[6:0] == OP_ASY) ? BUF_ASY : BUF_ISO;
        return c;
    endfunction

endpackage

// File: rtl/bufport_ctrl.sv
// Transfer sequencer: holds the active command, the byte pointer and the
// end-of-transfer compare. Produces write strobes with a high-lane enable
// and prefetch requests for the read path.
// Assumes: the count is stable for the duration of a transfer.
module bufport_ctrl
    import bufport_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  cmd_t             cmd,
    input  logic [CNT_W-1:0] cnt,
    input  logic             acc_wr,
    input  logic             acc_rd,
    output logic             active,
    output logic             wr_dir,
    output buf_sel_t         sel,
    output logic [CNT_W-1:0] ptr,
    output logic             mem_we,
    output logic             hi_en,
    output logic             pf_load,
    output buf_sel_t         pf_sel,
    output logic [CNT_W-1:0] pf_addr,
    output logic             eot,
    output buf_sel_t         eot_sel
);

    logic             start;
    logic             take;
    logic             last;
    logic [CNT_W:0]   ptr_ext_nx;
    logic [CNT_W:0]   ptr_ext_hi;

    // Decide whether this cycle starts a transfer or accepts an access.
    always_comb begin
        start      = cmd_we && cmd.valid;
        take       = active && !start && (wr_dir ? acc_wr : acc_rd);
        ptr_ext_nx = {1'b0, ptr} + (CNT_W+1)'(2);
        ptr_ext_hi = {1'b0, ptr} + (CNT_W+1)'(1);
        last       = ptr_ext_nx >= {1'b0, cnt};
        hi_en      = ptr_ext_hi < {1'b0, cnt};
        mem_we     = take && wr_dir;
    end

    // Pick what the read path should fetch next.
    always_comb begin
        pf_load = (start && !cmd.wr) || (take && !wr_dir && !last);
        pf_sel  = start ? cmd.sel : sel;
        pf_addr = start ? '0 : ptr_ext_nx[CNT_W-1:0];
    end

    // Sequencer state: command latch, pointer, end-of-transfer pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            wr_dir  <= 1'b0;
            sel     <= BUF_ISO;
            ptr     <= '0;
            eot     <= 1'b0;
            eot_sel <= BUF_ISO;
        end else begin
            eot <= 1'b0;
            if (start) begin
                wr_dir  <= cmd.wr;
                sel     <= cmd.sel;
                ptr     <= '0;
                active  <= (cnt != '0);
                eot     <= (cnt == '0);
                eot_sel <= cmd.sel;
            end else if (take) begin
                ptr <= ptr_ext_nx[CNT_W-1:0];
                if (last) begin
                    active  <= 1'b0;
                    eot     <= 1'b1;
                    eot_sel <= sel;
                end
            end
        end
    end

endmodule

// File: rtl/bufport_mem.sv
// Byte-organised buffer with a 16-bit lane view: the even byte is the low
// lane and the odd byte the high lane. Asynchronous word read.
// Assumes: DEPTH is a power of two, at least 4; addresses are even.
module bufport_mem #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          hi_en,
    input  logic [AW-1:0] waddr,
    input  logic [15:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);

    logic [7:0] bytes [DEPTH];
    logic [AW-1:0] w_even, w_odd, r_even, r_odd;

    // Form the lane addresses of the addressed byte pair.
    always_comb begin
        w_even = {waddr[AW-1:1], 1'b0};
        w_odd  = {waddr[AW-1:1], 1'b1};
        r_even = {raddr[AW-1:1], 1'b0};
        r_odd  = {raddr[AW-1:1], 1'b1};
        rdata  = {bytes[r_odd], bytes[r_even]};
    end

    // Store the low lane always and the high lane when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            bytes[w_even] <= wdata[7:0];
            if (hi_en) begin
                bytes[w_odd] <= wdata[15:8];
            end
        end
    end

endmodule

// File: rtl/bufport_flags.sv
// Sticky done interrupt (write-1-to-clear) and per-buffer completion flags.
// Assumes: eot is a one-cycle pulse; a set beats a same-cycle clear.
module bufport_flags #(
    parameter int ST_W     = 8,
    parameter int DONE_BIT = 2,
    parameter int NBUF     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eot,
    input  logic            eot_buf,
    input  logic            start,
    input  logic            start_buf,
    input  logic            clr_we,
    input  logic [ST_W-1:0] clr_data,
    output logic [ST_W-1:0] int_status,
    output logic [NBUF-1:0] buf_status
);

    logic done_q;

    // Sticky done flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (eot) begin
            done_q <= 1'b1;
        end else if (clr_we && clr_data[DONE_BIT]) begin
            done_q <= 1'b0;
        end
    end

    // Place the done flag at its bit; the rest read zero.
    always_comb begin
        int_status = ST_W'(done_q) << DONE_BIT;
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_bst
        logic hit_eot, hit_start;
        // Match the event buffer index against this flag.
        always_comb begin
            hit_eot   = eot   && (eot_buf   == 1'(g));
            hit_start = start && (start_buf == 1'(g));
        end
        // Completion flag per buffer; set beats a new-command clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                buf_status[g] <= 1'b0;
            end else if (hit_eot) begin
                buf_status[g] <= 1'b1;
            end else if (hit_start) begin
                buf_status[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bufport_top.sv
// Buffer access port top: command register, transfer-length register,
// two byte buffers, read prefetch register and status flags.
// Assumes: the processor loads the length before issuing the command.
module bufport_top
    import bufport_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int ST_W     = 8,
    parameter int DONE_BIT = 2,
    localparam int AW      = $clog2(DEPTH),
    localparam int CNT_W   = AW + 1,
    localparam int NBUF    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_code,
    input  logic             dat_wr,
    input  logic [15:0]      dat_wdata,
    input  logic             dat_rd,
    output logic [15:0]      dat_rdata,
    input  logic             int_clr_we,
    input  logic [ST_W-1:0]  int_clr_data,
    output logic [ST_W-1:0]  int_status,
    output logic             irq,
    output logic [NBUF-1:0]  buf_status,
    output logic             xfer_eot
);

    cmd_t             cmd_dec;
    logic [CNT_W-1:0] cnt_q;
    logic             ctrl_active;
    logic             ctrl_wr_dir;
    buf_sel_t         ctrl_sel;
    logic [CNT_W-1:0] ctrl_ptr;
    logic             mem_we;
    logic             hi_en;
    logic             pf_load;
    buf_sel_t         pf_sel;
    logic [CNT_W-1:0] pf_addr;
    buf_sel_t         eot_sel;
    logic             sel_b;
    logic             pf_sel_b;
    logic [15:0]      rd_word [NBUF];

    // Decode the command byte and flatten enum selects.
    always_comb begin
        cmd_dec  = decode_cmd(cmd_code);
        sel_b    = ctrl_sel;
        pf_sel_b = pf_sel;
    end

    // Transfer-length register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= cnt_wdata;
        end
    end

    bufport_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_we  (cmd_we),
        .cmd     (cmd_dec),
        .cnt     (cnt_q),
        .acc_wr  (dat_wr),
        .acc_rd  (dat_rd),
        .active  (ctrl_active),
        .wr_dir  (ctrl_wr_dir),
        .sel     (ctrl_sel),
        .ptr     (ctrl_ptr),
        .mem_we  (mem_we),
        .hi_en   (hi_en),
        .pf_load (pf_load),
        .pf_sel  (pf_sel),
        .pf_addr (pf_addr),
        .eot     (xfer_eot),
        .eot_sel (eot_sel)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        logic we_g;
        // Steer the write strobe to the selected buffer only.
        always_comb begin
            we_g = mem_we && ((g == 1) ? sel_b : !sel_b);
        end
        bufport_mem #(.DEPTH(DEPTH)) u_mem (
            .clk   (clk),
            .we    (we_g),
            .hi_en (hi_en),
            .waddr (ctrl_ptr[AW-1:0]),
            .wdata (dat_wdata),
            .raddr (pf_addr[AW-1:0]),
            .rdata (rd_word[g])
        );
    end

    // Read prefetch register presented on the data port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_rdata <= '0;
        end else if (pf_load) begin
            dat_rdata <= pf_sel_b ? rd_word[1] : rd_word[0];
        end
    end

    bufport_flags #(.ST_W(ST_W), .DONE_BIT(DONE_BIT), .NBUF(NBUF)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .eot        (xfer_eot),
        .eot_buf    (eot_sel),
        .start      (cmd_we && cmd_dec.valid),
        .start_buf  (cmd_dec.sel),
        .clr_we     (int_clr_we),
        .clr_data   (int_clr_data),
        .int_status (int_status),
        .buf_status (buf_status)
    );

    // Interrupt line follows the done flag.
    always_comb begin
        irq = int_status[DONE_BIT];
    end

endmodule

// File: rtl/bufport_chk.sv
// Property checker for bufport_top, attached with bind below.
// Assumes: DONE_BIT is 2 and status is 8 bits wide.
module bufport_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic [7:0]       cmd_code,
    input logic             dat_wr,
    input logic [15:0]      dat_rdata,
    input logic             int_clr_we,
    input logic [7:0]       int_clr_data,
    input logic [7:0]       int_status,
    input logic [1:0]       buf_status,
    input logic             xfer_eot,
    input logic             eot_sel,
    input logic             active,
    input logic             wr_dir,
    input logic [CNT_W-1:0] ptr,
    input logic [CNT_W-1:0] cnt
);

    logic cmd_ok;
    // Independent recognition of a valid command byte.
    always_comb begin
        cmd_ok = cmd_we && ((cmd_code[6:0] == 7'h40) || (cmd_code[6:0] == 7'h41));
    end

    a_r2_cmd_zero_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ok |=> (ptr == '0));

    a_r3_ptr_even: assert property (@(posedge clk) disable iff (!rst_n)
        ptr[0] == 1'b0);

    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cmd_ok && wr_dir && dat_wr) |=> (ptr == $past(ptr) + CNT_W'(2)));

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !cmd_ok) |=> ($stable(ptr) && $stable(dat_rdata)));

    a_r9_done_set: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_eot |=> int_status[2]);

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (int_status[2] && !(int_clr_we && int_clr_data[2])) |=> int_status[2]);

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int_status[1:0] == 2'b00) && (int_status[7:3] == 5'b0));

    a_r10_buf_set: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_eot |=> ($past(eot_sel) ? buf_status[1] : buf_status[0]));

    a_r11_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && (cnt == '0)) |=> (xfer_eot && !active));

endmodule

bind bufport_top bufport_chk #(.CNT_W(CNT_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_we       (cmd_we),
    .cmd_code     (cmd_code),
    .dat_wr       (dat_wr),
    .dat_rdata    (dat_rdata),
    .int_clr_we   (int_clr_we),
    .int_clr_data (int_clr_data),
    .int_status   (int_status),
    .buf_status   (buf_status),
    .xfer_eot     (xfer_eot),
    .eot_sel      (eot_sel),
    .active       (ctrl_active),
    .wr_dir       (ctrl_wr_dir),
    .ptr          (ctrl_ptr),
    .cnt          (cnt_q)
);

// File: tb/test_bufport_top.sv
// Self-checking bench: directed corners plus seeded random transfers,
// checked against a byte model of both buffers.
module test_bufport_top;

    localparam int DEPTH = 64;
    localparam int CNT_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_we = 1'b0;
    logic [CNT_W-1:0] cnt_wdata = '0;
    logic             cmd_we = 1'b0;
    logic [7:0]       cmd_code = '0;
    logic             dat_wr = 1'b0;
    logic [15:0]      dat_wdata = '0;
    logic             dat_rd = 1'b0;
    logic [15:0]      dat_rdata;
    logic             int_clr_we = 1'b0;
    logic [7:0]       int_clr_data = '0;
    logic [7:0]       int_status;
    logic             irq;
    logic [1:0]       buf_status;
    logic             xfer_eot;

    logic [7:0] mdl [2][DEPTH];
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bufport_top i_bufport_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_we       (cnt_we),
        .cnt_wdata    (cnt_wdata),
        .cmd_we       (cmd_we),
        .cmd_code     (cmd_code),
        .dat_wr       (dat_wr),
        .dat_wdata    (dat_wdata),
        .dat_rd       (dat_rd),
        .dat_rdata    (dat_rdata),
        .int_clr_we   (int_clr_we),
        .int_clr_data (int_clr_data),
        .int_status   (int_status),
        .irq          (irq),
        .buf_status   (buf_status),
        .xfer_eot     (xfer_eot)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int b, input int i);
        return {mdl[b][(2*i+1) % DEPTH], mdl[b][(2*i) % DEPTH]};
    endfunction

    function automatic logic [7:0] op_code(input int b, input bit wr);
        return {wr, 7'h40 | 7'(b)};
    endfunction

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic set_cnt(input int v);
        cnt_wdata = CNT_W'(v); cnt_we = 1'b1;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic do_cmd(input logic [7:0] code);
        cmd_code = code; cmd_we = 1'b1;
        @(negedge clk); cmd_we = 1'b0;
    endtask

    task automatic wr_acc(input logic [15:0] d);
        dat_wdata = d; dat_wr = 1'b1;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic rd_acc(output logic [15:0] w);
        w = dat_rdata; dat_rd = 1'b1;
        @(negedge clk); dat_rd = 1'b0;
    endtask

    task automatic clr_int(input logic [7:0] m);
        int_clr_data = m; int_clr_we = 1'b1;
        @(negedge clk); int_clr_we = 1'b0;
    endtask

    // Write transfer with model update and flag checks (R3, R6, R7, R9, R10).
    task automatic write_xfer(input int b, input int cnt);
        int nw = (cnt + 1) / 2;
        set_cnt(cnt);
        do_cmd(op_code(b, 1'b1));
        check("R10 cleared by command", 32'(buf_status[b]), 32'd0);
        for (int i = 0; i < nw; i++) begin
            logic [15:0] d = 16'($urandom);
            wr_acc(d);
            mdl[b][2*i] = d[7:0];
            if (2*i + 1 < cnt) mdl[b][2*i+1] = d[15:8];
            check("R6 eot timing", 32'(xfer_eot), 32'(i == nw - 1));
        end
        idle();
        check("R9 done bit set", 32'(int_status), 32'h4);
        check("R9 irq", 32'(irq), 32'd1);
        check("R10 buffer flag", 32'(buf_status[b]), 32'd1);
        clr_int(8'h04);
        check("R9 cleared", 32'(int_status), 32'd0);
    endtask

    // Read transfer compared word by word against the model (R4).
    task automatic read_xfer(input int b, input int cnt, input string tag);
        int nw = (cnt + 1) / 2;
        logic [15:0] w;
        set_cnt(cnt);
        do_cmd(op_code(b, 1'b0));
        for (int i = 0; i < nw; i++) begin
            rd_acc(w);
            check(tag, 32'(w), 32'(exp_word(b, i)));
            check("R6 read eot", 32'(xfer_eot), 32'(i == nw - 1));
        end
        idle();
        clr_int(8'h04);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] w, last_w;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R12 rdata", 32'(dat_rdata), 32'd0);
        check("R12 int_status", 32'(int_status), 32'd0);
        check("R12 irq", 32'(irq), 32'd0);
        check("R12 buf_status", 32'(buf_status), 32'd0);
        check("R12 eot", 32'(xfer_eot), 32'd0);

        // Fill both buffers, then read back (R2 R3 R4 R5).
        write_xfer(0, DEPTH);
        write_xfer(1, DEPTH);
        read_xfer(0, DEPTH, "R5 iso intact after async fill");
        read_xfer(1, DEPTH, "R4 async readback");

        // Odd count: final high byte must not be written (R7).
        write_xfer(1, 5);
        read_xfer(1, 8, "R7 odd count");

        // Write after eot is ignored (R8).
        write_xfer(0, 4);
        wr_acc(16'hDEAD);
        read_xfer(0, 8, "R8 write after eot");

        // Read after eot holds dat_rdata (R8).
        set_cnt(4);
        do_cmd(op_code(0, 1'b0));
        rd_acc(w);
        rd_acc(last_w);
        check("R4 second word", 32'(last_w), 32'(exp_word(0, 1)));
        rd_acc(w);
        check("R8 rdata held after eot", 32'(dat_rdata), 32'(last_w));
        idle(); clr_int(8'h04);

        // Wrong-direction access ignored during a write transfer (R8).
        set_cnt(8);
        do_cmd(op_code(0, 1'b1));
        for (int i = 0; i < 4; i++) begin
            logic [15:0] d = 16'h1100 + 16'(i);
            if (i == 1) rd_acc(w);
            wr_acc(d);
            mdl[0][2*i] = d[7:0]; mdl[0][2*i+1] = d[15:8];
        end
        check("R8 eot after four writes", 32'(xfer_eot), 32'd1);
        idle(); clr_int(8'h04);
        read_xfer(0, 8, "R8 wrong direction ignored");

        // Invalid codes mid-transfer leave it running (R1, R2).
        set_cnt(8);
        do_cmd(op_code(1, 1'b1));
        for (int i = 0; i < 4; i++) begin
            logic [15:0] d = 16'h2200 + 16'(i);
            if (i == 1) begin
                do_cmd(8'h42); do_cmd(8'h00); do_cmd(8'hC2);
            end
            wr_acc(d);
            mdl[1][2*i] = d[7:0]; mdl[1][2*i+1] = d[15:8];
        end
        check("R1 eot after invalid codes", 32'(xfer_eot), 32'd1);
        idle(); clr_int(8'h04);
        read_xfer(1, 8, "R1 invalid codes ignored");

        // Set and clear in the same cycle: set wins (R9).
        set_cnt(2);
        do_cmd(op_code(0, 1'b1));
        w = 16'hA55A;
        wr_acc(w);
        mdl[0][0] = w[7:0]; mdl[0][1] = w[15:8];
        check("R6 single word eot", 32'(xfer_eot), 32'd1);
        clr_int(8'h04);
        check("R9 set beats clear", 32'(int_status), 32'h4);
        clr_int(8'h04);
        check("R9 clear", 32'(int_status), 32'd0);

        // Zero count ends at once (R11).
        set_cnt(0);
        do_cmd(op_code(0, 1'b1));
        check("R11 immediate eot", 32'(xfer_eot), 32'd1);
        wr_acc(16'hBEEF);
        check("R11 done flag", 32'(int_status), 32'h4);
        clr_int(8'h04);
        read_xfer(0, 2, "R11 no access accepted");

        // Seeded random transfers.
        for (int t = 0; t < 40; t++) begin
            int b = int'($urandom_range(1, 0));
            int c = int'($urandom_range(DEPTH, 1));
            if ($urandom_range(1, 0) == 1) write_xfer(b, c);
            else read_xfer(b, c, "R4 random read");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule